// File: doc/BRIEF.md
# DMA transfer request sequencer

This block sits inside a compute component and handles every bulk movement between external memory and the component's local dual-port buffers. It never reads or writes external memory itself. For each transfer it first claims a shared DMA engine by reading a test-and-set lock register. It then programs the engine's control registers over a small memory-mapped master port. It sleeps until the engine raises its completion interrupt, clears that interrupt, gives the lock back, and pulses a done strobe to the compute logic.

The compute side has two request channels: a fill channel (external memory into a local buffer) and a write-back channel (local output buffer out to external memory). Each channel gives a descriptor in 128-bit word units: an external word index, a local word index and a word count. The block converts these to byte values, so every address and length the engine receives is a whole number of 16-byte words. The local buffer sits behind a separate slave window at a fixed base address, and the engine reaches it through that window. Requests that arrive while a transfer is running are held, one per channel, and served oldest first.

Top module: `dma_req_seq`

## Requirements
- R1: Out of reset, busRead, busWrite, rdDone and wrDone are low and rdReady is high.
- R2: The first bus operation of a transfer is a read of the lock address LOCK_ADDR. No write to a DMA register happens until a lock read has returned the value 1, which means granted (0 means busy).
- R3: When the lock read returns 0, the block issues no bus operation until lockIrq is high, and then it reads the lock again.
- R4: A transfer is programmed as four writes in this order: source byte address to DMA_BASE+1, destination byte address to DMA_BASE+2, byte length to DMA_BASE+3, and START_WORD to DMA_BASE+6. Byte address = word index × 16. The local side adds LOC_BASE. A fill moves data from external memory to the local buffer; a write-back moves it from the local buffer to external memory.
- R5: Every address and length written to DMA_BASE+1..+3 has its low four bits at zero.
- R6: While busWait is high, an active read or write is held with unchanged address, data and strobes. Read and write are never high together.
- R7: From the start write until dmaIrq is seen, the block issues no bus operation; it does not poll.
- R8: After dmaIrq, the block writes 0 to DMA_BASE+0 (interrupt clear), then writes 0 to LOCK_ADDR (release), then gives exactly one one-cycle pulse on rdDone or wrDone, whichever matches the channel.
- R9: wrReady is high only when no write-back is held and outLevel >= wrWords.
- R10: Held requests are served in arrival order. A fill and a write-back accepted in the same cycle are served fill first.
- R11: Each channel holds at most one request. After a request is accepted, that channel's ready stays low until the sequencer takes the request into service, so a request can be held while another transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | input | 1 | Fill request, accepted when rdReady is high |
| rdExtIdx | input | EXT_IW | External word index of the fill source |
| rdLocIdx | input | LOC_IW | Local buffer word index of the fill destination |
| rdWords | input | LEN_W | Fill length in 128-bit words |
| rdReady | output | 1 | Fill slot is empty |
| rdDone | output | 1 | One-cycle pulse when a fill finishes |
| wrReq | input | 1 | Write-back request, accepted when wrReady is high |
| wrExtIdx | input | EXT_IW | External word index of the write-back destination |
| wrLocIdx | input | LOC_IW | Local buffer word index of the write-back source |
| wrWords | input | LEN_W | Write-back length in 128-bit words |
| outLevel | input | LEN_W | Words currently held in the output buffer |
| wrReady | output | 1 | Write-back slot is empty and enough output data is present |
| wrDone | output | 1 | One-cycle pulse when a write-back finishes |
| busAddr | output | AW | Master port register address |
| busRead | output | 1 | Master port read strobe |
| busWrite | output | 1 | Master port write strobe |
| busWdata | output | DW | Master port write data |
| busRdata | input | DW | Master port read data, valid when busRead is high and busWait is low |
| busWait | input | 1 | Wait-request from the fabric |
| lockIrq | input | 1 | Lock-available interrupt, a level |
| dmaIrq | input | 1 | DMA completion interrupt, a level held until cleared |

## Verification
Some properties are checked on every cycle: a stalled bus operation stays stable, the length and addresses written are word-aligned, no DMA register is written without the lock, the block stays silent on the bus while a transfer runs, done pulses are one cycle long and exclusive, and an accepted write-back closes its slot. The values and the order of the whole programming sequence can only be shown by the bench's scenarios. So can the retry after a busy lock, the gating of write-backs by output fill level, and the service order of held requests (arrival order, and fill first on a tie). The bench compares every bus operation and done pulse against the sequence predicted from the requirements.

// File: rtl/dma_req_seq_pkg.sv
package dma_req_seq_pkg;

  // register offsets inside the DMA engine's control window
  localparam int OFF_STAT = 0;
  localparam int OFF_SRC  = 1;
  localparam int OFF_DST  = 2;
  localparam int OFF_LEN  = 3;
  localparam int OFF_CTL  = 6;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOCK_RD,
    OP_SRC,
    OP_DST,
    OP_LEN,
    OP_GO,
    OP_CLR,
    OP_UNLOCK
  } busOpE;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACQ,
    ST_LWAIT,
    ST_SRC,
    ST_DST,
    ST_LEN,
    ST_GO,
    ST_XWAIT,
    ST_CLR,
    ST_REL,
    ST_FIN
  } seqStateE;

  typedef struct packed {
    busOpE op;     // bus operation to present this cycle
    logic  pick;   // move the chosen held request into service
    logic  retire; // transfer finished, raise done
  } ctrlStrobeT;

endpackage

// File: rtl/dma_req_seq_ctrl.sv
module dma_req_seq_ctrl
  import dma_req_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pendAny,
  input  logic       busWait,
  input  logic       lockGrant,
  input  logic       lockIrq,
  input  logic       dmaIrq,
  output ctrlStrobeT stb
);

  seqStateE st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    stb    = '{op: OP_NONE, pick: 1'b0, retire: 1'b0};
    unique case (st)
      ST_IDLE: if (pendAny) begin
        stb.pick = 1'b1;
        stNext   = ST_ACQ;
      end
      ST_ACQ: begin
        stb.op = OP_LOCK_RD;
        if (!busWait) stNext = lockGrant ? ST_SRC : ST_LWAIT;
      end
      ST_LWAIT: if (lockIrq) stNext = ST_ACQ;
      ST_SRC: begin
        stb.op = OP_SRC;
        if (!busWait) stNext = ST_DST;
      end
      ST_DST: begin
        stb.op = OP_DST;
        if (!busWait) stNext = ST_LEN;
      end
      ST_LEN: begin
        stb.op = OP_LEN;
        if (!busWait) stNext = ST_GO;
      end
      ST_GO: begin
        stb.op = OP_GO;
        if (!busWait) stNext = ST_XWAIT;
      end
      ST_XWAIT: if (dmaIrq) stNext = ST_CLR;
      ST_CLR: begin
        stb.op = OP_CLR;
        if (!busWait) stNext = ST_REL;
      end
      ST_REL: begin
        stb.op = OP_UNLOCK;
        if (!busWait) stNext = ST_FIN;
      end
      ST_FIN: begin
        stb.retire = 1'b1;
        stNext     = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dma_req_seq_path.sv
module dma_req_seq_path
  import dma_req_seq_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 32,
  parameter int          EXT_IW    = 26,
  parameter int          LOC_IW    = 8,
  parameter int          LEN_W     = 12,
  parameter logic [AW-1:0] DMA_BASE  = 8'h10,
  parameter logic [AW-1:0] LOCK_ADDR = 8'h40,
  parameter logic [DW-1:0] LOC_BASE  = 32'h8000_0000,
  parameter logic [DW-1:0] START_WORD = 32'h0000_0007
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        stb,
  input  logic              rdReq,
  input  logic [EXT_IW-1:0] rdExtIdx,
  input  logic [LOC_IW-1:0] rdLocIdx,
  input  logic [LEN_W-1:0]  rdWords,
  input  logic              wrReq,
  input  logic [EXT_IW-1:0] wrExtIdx,
  input  logic [LOC_IW-1:0] wrLocIdx,
  input  logic [LEN_W-1:0]  wrWords,
  input  logic [LEN_W-1:0]  outLevel,
  output logic              rdReady,
  output logic              wrReady,
  output logic              pendAny,
  output logic [AW-1:0]     busAddr,
  output logic              busRead,
  output logic              busWrite,
  output logic [DW-1:0]     busWdata,
  output logic              rdDone,
  output logic              wrDone
);

  localparam int PAD_E = DW - EXT_IW - 4;
  localparam int PAD_L = DW - LOC_IW - 4;
  localparam int PAD_N = DW - LEN_W - 4;
  localparam logic [AW-1:0] A_STAT = DMA_BASE + AW'(OFF_STAT);
  localparam logic [AW-1:0] A_SRC  = DMA_BASE + AW'(OFF_SRC);
  localparam logic [AW-1:0] A_DST  = DMA_BASE + AW'(OFF_DST);
  localparam logic [AW-1:0] A_LEN  = DMA_BASE + AW'(OFF_LEN);
  localparam logic [AW-1:0] A_CTL  = DMA_BASE + AW'(OFF_CTL);

  logic              rdPend, wrPend, olderIsWr;
  logic [EXT_IW-1:0] rdExtQ, wrExtQ, curExt;
  logic [LOC_IW-1:0] rdLocQ, wrLocQ, curLoc;
  logic [LEN_W-1:0]  rdLenQ, wrLenQ, curLen;
  logic              curIsWr;
  logic              rdAcc, wrAcc, pickWr;
  logic [DW-1:0]     extByte, locByte, lenByte, srcByte, dstByte;

  assign rdReady = !rdPend;
  assign wrReady = !wrPend && (outLevel >= wrWords);
  assign rdAcc   = rdReq && rdReady;
  assign wrAcc   = wrReq && wrReady;
  assign pendAny = rdPend || wrPend;
  assign pickWr  = wrPend && (!rdPend || olderIsWr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend    <= 1'b0;
      wrPend    <= 1'b0;
      olderIsWr <= 1'b0;
      curIsWr   <= 1'b0;
      rdExtQ    <= '0; rdLocQ <= '0; rdLenQ <= '0;
      wrExtQ    <= '0; wrLocQ <= '0; wrLenQ <= '0;
      curExt    <= '0; curLoc <= '0; curLen <= '0;
      rdDone    <= 1'b0;
      wrDone    <= 1'b0;
    end else begin
      if (stb.pick) begin
        curIsWr <= pickWr;
        curExt  <= pickWr ? wrExtQ : rdExtQ;
        curLoc  <= pickWr ? wrLocQ : rdLocQ;
        curLen  <= pickWr ? wrLenQ : rdLenQ;
        if (pickWr) wrPend <= 1'b0;
        else        rdPend <= 1'b0;
      end
      if (rdAcc) begin
        rdPend <= 1'b1;
        rdExtQ <= rdExtIdx; rdLocQ <= rdLocIdx; rdLenQ <= rdWords;
      end
      if (wrAcc) begin
        wrPend <= 1'b1;
        wrExtQ <= wrExtIdx; wrLocQ <= wrLocIdx; wrLenQ <= wrWords;
      end
      // age bit: a same-cycle pair leaves the fill as older
      if (rdAcc)      olderIsWr <= wrPend;
      else if (wrAcc) olderIsWr <= !rdPend;
      rdDone <= stb.retire && !curIsWr;
      wrDone <= stb.retire && curIsWr;
    end
  end

  assign extByte = {{PAD_E{1'b0}}, curExt, 4'b0000};
  assign locByte = LOC_BASE | {{PAD_L{1'b0}}, curLoc, 4'b0000};
  assign lenByte = {{PAD_N{1'b0}}, curLen, 4'b0000};
  assign srcByte = curIsWr ? locByte : extByte;
  assign dstByte = curIsWr ? extByte : locByte;

  always_comb begin
    busAddr  = '0;
    busWdata = '0;
    busRead  = 1'b0;
    busWrite = 1'b0;
    unique case (stb.op)
      OP_LOCK_RD: begin busRead  = 1'b1; busAddr = LOCK_ADDR; end
      OP_SRC:     begin busWrite = 1'b1; busAddr = A_SRC;  busWdata = srcByte;    end
      OP_DST:     begin busWrite = 1'b1; busAddr = A_DST;  busWdata = dstByte;    end
      OP_LEN:     begin busWrite = 1'b1; busAddr = A_LEN;  busWdata = lenByte;    end
      OP_GO:      begin busWrite = 1'b1; busAddr = A_CTL;  busWdata = START_WORD; end
      OP_CLR:     begin busWrite = 1'b1; busAddr = A_STAT; end
      OP_UNLOCK:  begin busWrite = 1'b1; busAddr = LOCK_ADDR; end
      default: ;
    endcase
  end

endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_req_seq_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 32,
  parameter int          EXT_IW    = 26,
  parameter int          LOC_IW    = 8,
  parameter int          LEN_W     = 12,
  parameter logic [AW-1:0] DMA_BASE  = 8'h10,
  parameter logic [AW-1:0] LOCK_ADDR = 8'h40,
  parameter logic [DW-1:0] LOC_BASE  = 32'h8000_0000,
  parameter logic [DW-1:0] START_WORD = 32'h0000_0007
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic [EXT_IW-1:0] rdExtIdx,
  input  logic [LOC_IW-1:0] rdLocIdx,
  input  logic [LEN_W-1:0]  rdWords,
  output logic              rdReady,
  output logic              rdDone,
  input  logic              wrReq,
  input  logic [EXT_IW-1:0] wrExtIdx,
  input  logic [LOC_IW-1:0] wrLocIdx,
  input  logic [LEN_W-1:0]  wrWords,
  input  logic [LEN_W-1:0]  outLevel,
  output logic              wrReady,
  output logic              wrDone,
  output logic [AW-1:0]     busAddr,
  output logic              busRead,
  output logic              busWrite,
  output logic [DW-1:0]     busWdata,
  input  logic [DW-1:0]     busRdata,
  input  logic              busWait,
  input  logic              lockIrq,
  input  logic              dmaIrq
);

  ctrlStrobeT stb;
  logic       pendAny;
  logic       lockGrant;

  assign lockGrant = (busRdata == DW'(1));

  dma_req_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pendAny(pendAny), .busWait(busWait),
    .lockGrant(lockGrant), .lockIrq(lockIrq), .dmaIrq(dmaIrq), .stb(stb)
  );

  dma_req_seq_path #(
    .AW(AW), .DW(DW), .EXT_IW(EXT_IW), .LOC_IW(LOC_IW), .LEN_W(LEN_W),
    .DMA_BASE(DMA_BASE), .LOCK_ADDR(LOCK_ADDR), .LOC_BASE(LOC_BASE),
    .START_WORD(START_WORD)
  ) path_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdReq(rdReq), .rdExtIdx(rdExtIdx), .rdLocIdx(rdLocIdx), .rdWords(rdWords),
    .wrReq(wrReq), .wrExtIdx(wrExtIdx), .wrLocIdx(wrLocIdx), .wrWords(wrWords),
    .outLevel(outLevel), .rdReady(rdReady), .wrReady(wrReady), .pendAny(pendAny),
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite), .busWdata(busWdata),
    .rdDone(rdDone), .wrDone(wrDone)
  );

endmodule

// File: rtl/dma_req_seq_chk.sv
module dma_req_seq_chk
  import dma_req_seq_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 32,
  parameter logic [AW-1:0] DMA_BASE  = 8'h10,
  parameter logic [AW-1:0] LOCK_ADDR = 8'h40
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] busAddr,
  input logic          busRead,
  input logic          busWrite,
  input logic [DW-1:0] busWdata,
  input logic [DW-1:0] busRdata,
  input logic          busWait,
  input logic          dmaIrq,
  input logic          rdDone,
  input logic          wrDone,
  input logic          wrReq,
  input logic          wrReady
);

  localparam logic [AW-1:0] A_SRC = DMA_BASE + AW'(OFF_SRC);
  localparam logic [AW-1:0] A_DST = DMA_BASE + AW'(OFF_DST);
  localparam logic [AW-1:0] A_LEN = DMA_BASE + AW'(OFF_LEN);
  localparam logic [AW-1:0] A_CTL = DMA_BASE + AW'(OFF_CTL);

  logic owned, inWait;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owned  <= 1'b0;
      inWait <= 1'b0;
    end else begin
      if (busRead && !busWait && busAddr == LOCK_ADDR && busRdata == DW'(1)) owned <= 1'b1;
      else if (busWrite && !busWait && busAddr == LOCK_ADDR) owned <= 1'b0;
      if (busWrite && !busWait && busAddr == A_CTL) inWait <= 1'b1;
      else if (dmaIrq) inWait <= 1'b0;
    end
  end

  AST_OWNED_BEFORE_PROGRAM: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busAddr != LOCK_ADDR |-> owned); // R2

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (busRead || busWrite) && busWait |=>
      $stable(busAddr) && $stable(busWdata) && $stable(busRead) && $stable(busWrite)); // R6

  AST_NO_READ_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite)); // R6

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && (busAddr == A_SRC || busAddr == A_DST || busAddr == A_LEN)
      |-> busWdata[3:0] == 4'h0); // R5

  AST_NO_POLL: assert property (@(posedge clk) disable iff (!rstN)
    inWait |-> !busRead && !busWrite); // R7

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdDone, wrDone})); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (rdDone || wrDone) |=> !rdDone && !wrDone); // R8

  AST_SLOT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && wrReady |=> !wrReady); // R11

endmodule

bind dma_req_seq dma_req_seq_chk #(
  .AW(AW), .DW(DW), .DMA_BASE(DMA_BASE), .LOCK_ADDR(LOCK_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
  .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
  .busWait(busWait), .dmaIrq(dmaIrq), .rdDone(rdDone), .wrDone(wrDone),
  .wrReq(wrReq), .wrReady(wrReady)
);

// File: tb/dma_req_seq_tb_top.sv
`timescale 1ns/1ps
module dma_req_seq_tb_top;

  localparam int AW = 8, DW = 32, EXT_IW = 26, LOC_IW = 8, LEN_W = 12;
  localparam logic [7:0]  DMA_BASE = 8'h10;
  localparam logic [7:0]  LOCK_A   = 8'h40;
  localparam logic [31:0] LOC_BASE = 32'h8000_0000;
  localparam logic [31:0] START_W  = 32'h0000_0007;
  localparam int DMA_LAT = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic              rdReq = 0, wrReq = 0;
  logic [EXT_IW-1:0] rdExtIdx = '0, wrExtIdx = '0;
  logic [LOC_IW-1:0] rdLocIdx = '0, wrLocIdx = '0;
  logic [LEN_W-1:0]  rdWords = '0, wrWords = '0, outLevel = '0;
  logic              rdReady, wrReady, rdDone, wrDone;
  logic [AW-1:0]     busAddr;
  logic              busRead, busWrite, busWait;
  logic [DW-1:0]     busWdata, busRdata;
  logic              lockIrq;
  logic              dmaIrq = 0;

  logic lockOther = 0, lockOwned = 0, stallEn = 0, inWaitTb = 0;
  logic [1:0] stallCnt = 0;
  int dmaCnt = 0, goCnt = 0;
  int total = 0, bad = 0;

  dma_req_seq dut_i (.*);

  assign busWait  = stallEn && (stallCnt != 2'd0);
  assign lockIrq  = !lockOther && !lockOwned;
  assign busRdata = (busRead && busAddr == LOCK_A && !lockOther && !lockOwned) ? 32'd1 : 32'd0;

  // lock peripheral, DMA engine and fabric stall models
  always @(posedge clk) begin
    stallCnt <= stallCnt + 2'd1;
    if (busRead && !busWait && busAddr == LOCK_A && !lockOther && !lockOwned) lockOwned <= 1'b1;
    if (busWrite && !busWait && busAddr == LOCK_A) lockOwned <= 1'b0;
    if (busWrite && !busWait && busAddr == DMA_BASE + 8'd6) begin
      dmaCnt <= DMA_LAT; goCnt <= goCnt + 1; inWaitTb <= 1'b1;
    end else if (dmaCnt > 1) dmaCnt <= dmaCnt - 1;
    else if (dmaCnt == 1) begin dmaCnt <= 0; dmaIrq <= 1'b1; end
    if (dmaIrq) inWaitTb <= 1'b0;
    if (busWrite && !busWait && busAddr == DMA_BASE) dmaIrq <= 1'b0;
  end

  typedef struct { int kind; logic [7:0] addr; logic [31:0] data; string req; } evT;
  evT expQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pushEv(input int k, input logic [7:0] a, input logic [31:0] d, input string r);
    evT e; e.kind = k; e.addr = a; e.data = d; e.req = r;
    expQ.push_back(e);
  endtask

  // kinds: 0 read, 1 write, 2 fill done, 3 write-back done
  task automatic expectXfer(input bit isWr, input int ext, input int loc, input int len,
                            input int fails, input string ordReq);
    logic [31:0] eB, lB;
    eB = 32'(ext) << 4;
    lB = LOC_BASE | (32'(loc) << 4);
    for (int i = 0; i < fails; i++) pushEv(0, LOCK_A, 32'd0, "R3");
    pushEv(0, LOCK_A, 32'd1, "R2");
    pushEv(1, DMA_BASE + 8'd1, isWr ? lB : eB, "R4");
    pushEv(1, DMA_BASE + 8'd2, isWr ? eB : lB, "R4");
    pushEv(1, DMA_BASE + 8'd3, 32'(len) << 4, "R5");
    pushEv(1, DMA_BASE + 8'd6, START_W, "R4");
    pushEv(1, DMA_BASE, 32'd0, "R8");
    pushEv(1, LOCK_A, 32'd0, "R8");
    pushEv(isWr ? 3 : 2, 8'd0, 32'd0, ordReq);
  endtask

  task automatic got(input int k, input logic [7:0] a, input logic [31:0] d);
    evT e;
    if (expQ.size() == 0) begin
      check(1'b0, "R10", "unexpected event kind", 32'(k), 32'hFFFF_FFFF);
      return;
    end
    e = expQ.pop_front();
    check(k == e.kind, e.req, "event kind", 32'(k), 32'(e.kind));
    if (k < 2) begin
      check(a == e.addr, e.req, "bus address", 32'(a), 32'(e.addr));
      check(d == e.data, e.req, "bus data", d, e.data);
    end
  endtask

  // monitor
  always @(negedge clk) if (rstN) begin
    if (busRead && !busWait)  got(0, busAddr, busRdata);
    if (busWrite && !busWait) got(1, busAddr, busWdata);
    if (rdDone) got(2, 8'd0, 32'd0);
    if (wrDone) got(3, 8'd0, 32'd0);
    if (inWaitTb && (busRead || busWrite))
      check(1'b0, "R7", "bus activity during transfer", 32'(busAddr), 32'd0);
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired, pending=%0d expected=0", expQ.size());
    summary();
  end

  task automatic issueRd(input int ext, input int loc, input int len);
    @(negedge clk);
    rdExtIdx = EXT_IW'(ext); rdLocIdx = LOC_IW'(loc); rdWords = LEN_W'(len); rdReq = 1;
    @(negedge clk); rdReq = 0;
  endtask

  task automatic issueWr(input int ext, input int loc, input int len);
    @(negedge clk);
    wrExtIdx = EXT_IW'(ext); wrLocIdx = LOC_IW'(loc); wrWords = LEN_W'(len); wrReq = 1;
    @(negedge clk); wrReq = 0;
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int g0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busRead && !busWrite, "R1", "bus strobes in reset", {30'd0, busRead, busWrite}, 0);
    check(!rdDone && !wrDone, "R1", "done in reset", {30'd0, rdDone, wrDone}, 0);
    check(rdReady, "R1", "rdReady in reset", 32'(rdReady), 1);
    rstN = 1;
    @(negedge clk);

    // basic fill, no stall (R2 R4 R5 R8)
    expectXfer(0, 'h12345, 3, 4, 0, "R8");
    issueRd('h12345, 3, 4);
    drain();

    // R9: write-back gated by output fill level
    wrWords = 12'd8; outLevel = 12'd4;
    @(negedge clk);
    check(!wrReady, "R9", "wrReady with short output buffer", 32'(wrReady), 0);
    outLevel = 12'd8;
    @(negedge clk);
    check(wrReady, "R9", "wrReady with enough output data", 32'(wrReady), 1);

    // write-back under wait-request stalls (R4 R6)
    stallEn = 1;
    expectXfer(1, 'h2000, 'h40, 8, 0, "R8");
    issueWr('h2000, 'h40, 8);
    drain();
    stallEn = 0;

    // R3: lock busy, one failed read, then silence until lockIrq
    lockOther = 1;
    expectXfer(0, 'h777, 9, 2, 1, "R3");
    issueRd('h777, 9, 2);
    repeat (40) @(negedge clk);
    check(expQ.size() == 8, "R3", "events left while lock busy", 32'(expQ.size()), 8);
    lockOther = 0;
    drain();

    // R10 arrival order: fill in flight, write-back then fill held
    outLevel = 12'd100;
    g0 = goCnt;
    expectXfer(0, 'h100, 1, 1, 0, "R10");
    expectXfer(1, 'h200, 2, 5, 0, "R10");
    expectXfer(0, 'h300, 3, 6, 0, "R10");
    issueRd('h100, 1, 1);
    wait (goCnt == g0 + 1);
    issueWr('h200, 2, 5);
    check(!wrReady, "R11", "wrReady while write-back held", 32'(wrReady), 0);
    @(negedge clk);
    issueRd('h300, 3, 6);
    check(!rdReady, "R11", "rdReady while fill held", 32'(rdReady), 0);
    drain();

    // R10 tie: fill and write-back in the same cycle, fill first
    g0 = goCnt;
    expectXfer(0, 'h500, 5, 3, 0, "R10");
    expectXfer(0, 'h600, 6, 2, 0, "R10");
    expectXfer(1, 'h700, 7, 9, 0, "R10");
    issueRd('h500, 5, 3);
    wait (goCnt == g0 + 1);
    @(negedge clk);
    rdExtIdx = 'h600; rdLocIdx = 6; rdWords = 2; rdReq = 1;
    wrExtIdx = 'h700; wrLocIdx = 7; wrWords = 9; wrReq = 1;
    @(negedge clk); rdReq = 0; wrReq = 0;
    drain();

    check(expQ.size() == 0, "R10", "all expected events seen", 32'(expQ.size()), 0);
    summary();
  end

endmodule